// File: doc/BRIEF.md
# Event Routing Channel with Edge Detection

This block is one channel of an event routing fabric. An 8-bit selector picks a single line out of a bank of event generator inputs, and the chosen line is carried to the channel output along one of three paths. The asynchronous path passes the raw level straight through with no clocking. The synchronous path samples the level in one flop. The resynchronized path first runs the level through a synchronizer of two flops. On both clocked paths an edge detector turns level changes into one-cycle event pulses. It can detect rising edges, falling edges, both, or neither.

One 32-bit configuration word, written in a single access, sets up the channel. It holds the selector, the path, the edge mode, a flag that keeps the channel running in standby, and a flag that makes the channel's clock request on-demand. The block drives a clock-request output for the clock controller and gates itself off during standby unless it is told to keep running. Only channels with a low index (below `SYNC_CHAN_LIMIT`, 4 by default) have the clocked paths. A higher channel that is asked for a clocked path runs asynchronously instead.

Top module: `evt_route_chan`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00008000. A write stores the configuration word with the following fields: selector in bits 7:0, path in bits 9:8, edge mode in bits 11:10, run-in-standby in bit 14 and on-demand in bit 15. Bits 13:12 and 31:16 always read 0.
- R2: `gen_in[sel]` is the selected line. A selector value at or above `NUM_GEN` selects a constant low, and lines that are not selected have no effect on `evt_out`.
- R3: With path code 2 (asynchronous), `evt_out` equals the selected level in the same cycle, whatever the edge-mode field holds.
- R4: With path code 0 (synchronous), edge code 0 gives no pulses, 1 gives rising edges only, 2 gives falling edges only and 3 gives both. A detected edge gives a pulse one cycle wide. The pulse is high after the second rising clock edge that follows the input change.
- R5: With path code 1 (resynchronized), the same edge coding applies, and the pulse comes one clock cycle later than on the synchronous path.
- R6: With path code 3 (reserved), `evt_out` and `clk_req` stay low.
- R7: On a channel whose `CHAN_IDX` is at least `SYNC_CHAN_LIMIT`, path codes 0 and 1 behave as path code 2.
- R8: With on-demand (bit 15) at 0, `clk_req` is high whenever the path code is valid and the channel is not gated by standby.
- R9: With on-demand at 1, `clk_req` is high only while a level change is moving through the clocked path or a pulse is being output. It is low when the channel is idle, and always low on the asynchronous path.
- R10: While `standby_i` is high and run-in-standby (bit 14) is 0, `evt_out` and `clk_req` are low. With run-in-standby at 1, the channel behaves as it does outside standby.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Stored configuration word |
| gen_in | input | NUM_GEN | Event generator lines |
| standby_i | input | 1 | System is in standby |
| evt_out | output | 1 | Channel event output (a level on the asynchronous path, pulses on the clocked paths) |
| clk_req | output | 1 | Request for the channel clock |

## Verification
The assertions check, on every cycle, the parts of the behaviour that do not depend on history. The reserved path and standby gating must silence both outputs. An always-on request must be present whenever the channel is configured and active. The asynchronous path must pass the selected level through. A higher channel must never use the clocked paths. The assertions also check that a written word reads back with its reserved bits cleared and that a rising-only detector never gives two pulses in a row. Only the bench's scenarios show the exact cycle on which a pulse appears on each path, the edge polarity for each mode, the bounded request window in on-demand mode, and that unselected or out-of-range generator lines are ignored.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;

   localparam int CFG_W    = 32;
   localparam int SEL_W    = 8;
   localparam int SEL_LSB  = 0;
   localparam int PATH_LSB = 8;
   localparam int EDGE_LSB = 10;
   localparam int STBY_BIT = 14;
   localparam int OD_BIT   = 15;

   localparam logic [CFG_W-1:0] CFG_MASK =
      (CFG_W'((1 << SEL_W) - 1) << SEL_LSB) |
      (CFG_W'(3) << PATH_LSB) |
      (CFG_W'(3) << EDGE_LSB) |
      (CFG_W'(1) << STBY_BIT) |
      (CFG_W'(1) << OD_BIT);

   typedef enum logic [1:0] {
      PATH_SYNC   = 2'd0,
      PATH_RESYNC = 2'd1,
      PATH_ASYNC  = 2'd2,
      PATH_RSVD   = 2'd3
   } path_e;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_BOTH = 2'd3
   } edge_e;

   typedef struct packed {
      logic             on_demand;
      logic             run_stby;
      edge_e            edge_mode;
      path_e            path;
      logic [SEL_W-1:0] gen_sel;
   } chan_cfg_t;

   localparam chan_cfg_t CFG_RST = '{
      on_demand: 1'b1,
      run_stby:  1'b0,
      edge_mode: EDGE_NONE,
      path:      PATH_SYNC,
      gen_sel:   '0
   };

   function automatic logic [CFG_W-1:0] cfg_pack(input chan_cfg_t c);
      logic [CFG_W-1:0] w;
      w = '0;
      w[SEL_LSB +: SEL_W] = c.gen_sel;
      w[PATH_LSB +: 2]    = c.path;
      w[EDGE_LSB +: 2]    = c.edge_mode;
      w[STBY_BIT]         = c.run_stby;
      w[OD_BIT]           = c.on_demand;
      return w;
   endfunction

   function automatic chan_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
      chan_cfg_t c;
      c.gen_sel   = w[SEL_LSB +: SEL_W];
      c.path      = path_e'(w[PATH_LSB +: 2]);
      c.edge_mode = edge_e'(w[EDGE_LSB +: 2]);
      c.run_stby  = w[STBY_BIT];
      c.on_demand = w[OD_BIT];
      return c;
   endfunction

endpackage

// File: rtl/evt_chan_cfg.sv
module evt_chan_cfg
   import evt_route_pkg::*;
#(
   parameter int CHAN_IDX        = 0,
   parameter int SYNC_CHAN_LIMIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] rdata,
   output chan_cfg_t        cfg,
   output path_e            eff_path
);

   localparam bit SYNC_OK = (CHAN_IDX < SYNC_CHAN_LIMIT);

   chan_cfg_t cfg_q;
   logic      unused_wbits;

   assign unused_wbits = ^(wdata & ~CFG_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RST;
      end else if (we) begin
         cfg_q <= cfg_unpack(wdata);
      end
   end

   assign cfg   = cfg_q;
   assign rdata = cfg_pack(cfg_q);

   generate
      if (SYNC_OK) begin : g_all_paths
         assign eff_path = cfg_q.path;
      end else begin : g_async_only
         always_comb begin
            if (cfg_q.path == PATH_SYNC || cfg_q.path == PATH_RESYNC)
               eff_path = PATH_ASYNC;
            else
               eff_path = cfg_q.path;
         end
      end
   endgenerate

   AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata == ($past(wdata) & CFG_MASK)));  // R1
   AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~CFG_MASK) == '0);  // R1

endmodule

// File: rtl/evt_gen_mux.sv
module evt_gen_mux
   import evt_route_pkg::*;
#(
   parameter int NUM_GEN = 256
) (
   input  logic [NUM_GEN-1:0] gen_in,
   input  logic [SEL_W-1:0]   sel,
   output logic               sel_sig
);

   localparam int SPAN = 1 << SEL_W;

   logic [SPAN-1:0] padded;

   generate
      for (genvar i = 0; i < SPAN; i++) begin : g_pad
         if (i < NUM_GEN) begin : g_live
            assign padded[i] = gen_in[i];
         end else begin : g_dead
            assign padded[i] = 1'b0;
         end
      end
   endgenerate

   assign sel_sig = padded[sel];

endmodule

// File: rtl/evt_edge_det.sv
module evt_edge_det
   import evt_route_pkg::*;
#(
   parameter int STAGES = 1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  d,
   input  edge_e mode,
   output logic  evt,
   output logic  busy
);

   logic [STAGES-1:0] st;
   logic              prev;
   logic              last;
   logic              evt_q;
   logic              rise, fall, hit;
   logic [STAGES+1:0] chain;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("evt_edge_det: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= '0;
            else        st <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= '0;
            else        st <= {st[STAGES-2:0], d};
         end
      end
   endgenerate

   assign last = st[STAGES-1];
   assign rise = last & ~prev;
   assign fall = ~last & prev;

   always_comb begin
      unique case (mode)
         EDGE_RISE: hit = rise;
         EDGE_FALL: hit = fall;
         EDGE_BOTH: hit = rise | fall;
         default:   hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= 1'b0;
         evt_q <= 1'b0;
      end else begin
         prev  <= last;
         evt_q <= hit;
      end
   end

   assign chain = {d, st, prev};
   assign evt   = evt_q;
   assign busy  = evt_q | ~((&chain) | ~(|chain));

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q && mode == EDGE_RISE && $past(mode) == EDGE_RISE) |=> !evt_q);  // R4

endmodule

// File: rtl/evt_route_chan.sv
module evt_route_chan
   import evt_route_pkg::*;
#(
   parameter int CHAN_IDX        = 0,
   parameter int NUM_GEN         = 256,
   parameter int SYNC_CHAN_LIMIT = 4,
   parameter int RESYNC_STAGES   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CFG_W-1:0]   cfg_wdata,
   output logic [CFG_W-1:0]   cfg_rdata,
   input  logic [NUM_GEN-1:0] gen_in,
   input  logic               standby_i,
   output logic               evt_out,
   output logic               clk_req
);

   localparam bit SYNC_OK = (CHAN_IDX < SYNC_CHAN_LIMIT);

   generate
      if (NUM_GEN < 1 || NUM_GEN > (1 << SEL_W)) begin : g_bad_num_gen
         $error("evt_route_chan: NUM_GEN out of range");
      end
      if (RESYNC_STAGES < 2) begin : g_bad_resync
         $error("evt_route_chan: RESYNC_STAGES must be at least 2");
      end
      if (CHAN_IDX < 0) begin : g_bad_idx
         $error("evt_route_chan: CHAN_IDX must not be negative");
      end
   endgenerate

   chan_cfg_t cfg;
   path_e     eff_path;
   logic      sel_sig;
   logic      sync_evt, sync_busy;
   logic      resync_evt, resync_busy;
   logic      active, path_ok;
   logic      path_evt, path_busy;

   evt_chan_cfg #(
      .CHAN_IDX        (CHAN_IDX),
      .SYNC_CHAN_LIMIT (SYNC_CHAN_LIMIT)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .wdata    (cfg_wdata),
      .rdata    (cfg_rdata),
      .cfg      (cfg),
      .eff_path (eff_path)
   );

   evt_gen_mux #(
      .NUM_GEN (NUM_GEN)
   ) u_mux (
      .gen_in  (gen_in),
      .sel     (cfg.gen_sel),
      .sel_sig (sel_sig)
   );

   generate
      if (SYNC_OK) begin : g_clocked
         evt_edge_det #(.STAGES(1)) u_sync_det (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (sel_sig),
            .mode  (cfg.edge_mode),
            .evt   (sync_evt),
            .busy  (sync_busy)
         );
         evt_edge_det #(.STAGES(RESYNC_STAGES)) u_resync_det (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (sel_sig),
            .mode  (cfg.edge_mode),
            .evt   (resync_evt),
            .busy  (resync_busy)
         );
      end else begin : g_no_clocked
         logic unused_edge_mode;
         assign unused_edge_mode = ^cfg.edge_mode;
         assign sync_evt    = 1'b0;
         assign sync_busy   = 1'b0;
         assign resync_evt  = 1'b0;
         assign resync_busy = 1'b0;
      end
   endgenerate

   assign active  = ~standby_i | cfg.run_stby;
   assign path_ok = (eff_path != PATH_RSVD);

   always_comb begin
      unique case (eff_path)
         PATH_SYNC:   begin path_evt = sync_evt;   path_busy = sync_busy;   end
         PATH_RESYNC: begin path_evt = resync_evt; path_busy = resync_busy; end
         PATH_ASYNC:  begin path_evt = sel_sig;    path_busy = 1'b0;        end
         default:     begin path_evt = 1'b0;       path_busy = 1'b0;        end
      endcase
   end

   assign evt_out = active & path_evt;
   assign clk_req = active & path_ok & (~cfg.on_demand | path_busy);

   AST_RSVD_PATH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.path == PATH_RSVD) |-> (!evt_out && !clk_req));  // R6
   AST_STBY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (standby_i && !cfg.run_stby) |-> (!evt_out && !clk_req));  // R10
   AST_ALWAYS_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.on_demand && !standby_i && cfg.path != PATH_RSVD) |-> clk_req);  // R8
   AST_ASYNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.path == PATH_ASYNC && !standby_i) |-> (evt_out == sel_sig));  // R3
   AST_ASYNC_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.path == PATH_ASYNC && cfg.on_demand) |-> !clk_req);  // R9

   generate
      if (!SYNC_OK) begin : g_hi_chk
         AST_HIGH_CHAN_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg.path != PATH_RSVD && !standby_i) |-> (evt_out == sel_sig));  // R7
      end
   endgenerate

endmodule

// File: tb/evt_route_chan_bench.sv
module evt_route_chan_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NG         = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [31:0]   cfg_wdata = '0;
   logic [NG-1:0] gen_in = '0;
   logic          standby_i = 1'b0;
   logic [31:0]   rd_lo, rd_hi;
   logic          evt_lo, evt_hi, req_lo, req_hi;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_route_chan #(.CHAN_IDX(0), .NUM_GEN(NG)) u_evt_route_chan (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
      .cfg_rdata (rd_lo), .gen_in (gen_in), .standby_i (standby_i),
      .evt_out (evt_lo), .clk_req (req_lo));

   evt_route_chan #(.CHAN_IDX(5), .NUM_GEN(NG)) u_evt_route_chan_hi (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_wdata (cfg_wdata),
      .cfg_rdata (rd_hi), .gen_in (gen_in), .standby_i (standby_i),
      .evt_out (evt_hi), .clk_req (req_hi));

   typedef struct {
      bit          hi;
      bit          is_cfg;
      logic [31:0] cfg;
      logic        evt;
      logic        req;
      string       tag;
   } exp_t;

   exp_t sb[$];

   // monitor: pop and compare every pending expectation mid-cycle
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0) begin
            exp_t it;
            logic [31:0] a_cfg;
            logic a_evt, a_req;
            it    = sb.pop_front();
            a_cfg = it.hi ? rd_hi  : rd_lo;
            a_evt = it.hi ? evt_hi : evt_lo;
            a_req = it.hi ? req_hi : req_lo;
            n_vec++;
            if (it.is_cfg) begin
               if (a_cfg !== it.cfg) begin
                  n_fail++;
                  $display("FAIL %s cfg=%h exp=%h", it.tag, a_cfg, it.cfg);
               end
            end else if (a_evt !== it.evt || a_req !== it.req) begin
               n_fail++;
               $display("FAIL %s evt=%b exp=%b req=%b exp=%b",
                        it.tag, a_evt, it.evt, a_req, it.req);
            end
         end
      end
   end

   task automatic cyc(input bit hi, input logic e, input logic r, input string tag);
      exp_t it;
      it.hi = hi; it.is_cfg = 1'b0; it.cfg = '0; it.evt = e; it.req = r; it.tag = tag;
      sb.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic cfgchk(input bit hi, input logic [31:0] v, input string tag);
      exp_t it;
      it.hi = hi; it.is_cfg = 1'b1; it.cfg = v; it.evt = 1'b0; it.req = 1'b0; it.tag = tag;
      sb.push_back(it);
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [31:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   // expected outputs over the cycles after a level change on the selected line
   task automatic edge_run(input int lat, input bit pulse, input bit od,
                           input bit req_const, input string tag);
      for (int i = 0; i <= lat + 1; i++) begin
         logic e, r;
         e = pulse && (i == lat);
         r = od ? ((i < lat) || (pulse && i == lat)) : req_const;
         cyc(1'b0, e, r, tag);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      cfgchk(0, 32'h0000_8000, "R1 reset value");
      cyc(0, 0, 0, "R1 reset outputs idle");

      // R1 reserved bits, R6 reserved path
      wr(32'hFFFF_FFFF);
      cfgchk(0, 32'h0000_CFFF, "R1 reserved bits read zero");
      cyc(0, 0, 0, "R6 all-ones word quiet");
      wr(32'h0000_0305);
      gen_in[5] = 1'b1;
      repeat (3) cyc(0, 0, 0, "R6 reserved path rise");
      gen_in[5] = 1'b0;
      repeat (3) cyc(0, 0, 0, "R6 reserved path fall");

      // R4 synchronous, rising only, always-on request (R8)
      wr(32'h0000_0405);
      cfgchk(0, 32'h0000_0405, "R1 write readback");
      cyc(0, 0, 1, "R8 request while idle");
      gen_in[5] = 1'b1; edge_run(2, 1, 0, 1, "R4 rise mode rising edge");
      gen_in[5] = 1'b0; edge_run(2, 0, 0, 1, "R4 rise mode ignores fall");

      // R4 falling only
      wr(32'h0000_0805);
      gen_in[5] = 1'b1; edge_run(2, 0, 0, 1, "R4 fall mode ignores rise");
      gen_in[5] = 1'b0; edge_run(2, 1, 0, 1, "R4 fall mode falling edge");

      // R4 both edges
      wr(32'h0000_0C05);
      gen_in[5] = 1'b1; edge_run(2, 1, 0, 1, "R4 both mode rise");
      gen_in[5] = 1'b0; edge_run(2, 1, 0, 1, "R4 both mode fall");

      // R4 no-event mode
      wr(32'h0000_0005);
      gen_in[5] = 1'b1; edge_run(2, 0, 0, 1, "R4 none mode rise");
      gen_in[5] = 1'b0; edge_run(2, 0, 0, 1, "R4 none mode fall");

      // R9 on-demand on the synchronous path
      wr(32'h0000_8405);
      cyc(0, 0, 0, "R9 no request while idle");
      gen_in[5] = 1'b1; edge_run(2, 1, 1, 0, "R9 sync on-demand window");
      gen_in[5] = 1'b0; edge_run(2, 0, 1, 0, "R9 sync on-demand no pulse");

      // R5 resynchronized path
      wr(32'h0000_8507);
      gen_in[7] = 1'b1; edge_run(3, 1, 1, 0, "R5 resync pulse and R9 window");
      gen_in[7] = 1'b0; edge_run(3, 0, 1, 0, "R5 resync fall ignored");
      wr(32'h0000_0D07);
      gen_in[7] = 1'b1; edge_run(3, 1, 0, 1, "R5 resync both rise");
      gen_in[7] = 1'b0; edge_run(3, 1, 0, 1, "R5 resync both fall");

      // R3 asynchronous path, edge field ignored
      wr(32'h0000_0E09);
      gen_in[9] = 1'b1;
      cyc(0, 1, 1, "R3 async follows high");
      cyc(0, 1, 1, "R3 async holds high");
      gen_in[9] = 1'b0;
      cyc(0, 0, 1, "R3 async follows low");
      wr(32'h0000_8209);
      gen_in[9] = 1'b1;
      cyc(0, 1, 0, "R9 async on-demand no request");
      gen_in[9] = 1'b0;
      cyc(0, 0, 0, "R9 async on-demand low");

      // R2 selection
      wr(32'h0000_02FA);
      gen_in = '1;
      cyc(0, 0, 1, "R2 out-of-range selector low");
      gen_in = '0;
      wr(32'h0000_0203);
      gen_in[4] = 1'b1;
      cyc(0, 0, 1, "R2 neighbour line ignored");
      gen_in[3] = 1'b1;
      cyc(0, 1, 1, "R2 selected line passes");
      gen_in = '0;
      cyc(0, 0, 1, "R2 selected line low");

      // R10 standby gating
      wr(32'h0000_0405);
      standby_i = 1'b1;
      cyc(0, 0, 0, "R10 request gated in standby");
      gen_in[5] = 1'b1; edge_run(2, 0, 0, 0, "R10 events gated in standby");
      gen_in[5] = 1'b0;
      repeat (3) cyc(0, 0, 0, "R10 gated settle");
      wr(32'h0000_4405);
      cyc(0, 0, 1, "R10 run-in-standby request");
      gen_in[5] = 1'b1; edge_run(2, 1, 0, 1, "R10 run-in-standby pulse");
      gen_in[5] = 1'b0; edge_run(2, 0, 0, 1, "R10 run-in-standby fall");
      standby_i = 1'b0;

      // R7 high channel treats clocked paths as asynchronous
      wr(32'h0000_0405);
      cfgchk(1, 32'h0000_0405, "R7 high channel stores word");
      cyc(1, 0, 1, "R7 high channel idle");
      gen_in[5] = 1'b1;
      cyc(1, 1, 1, "R7 high channel passes level");
      cyc(1, 1, 1, "R7 high channel holds level");
      gen_in[5] = 1'b0;
      cyc(1, 0, 1, "R7 high channel low");
      wr(32'h0000_0505);
      gen_in[5] = 1'b1;
      cyc(1, 1, 1, "R7 high channel resync as async");
      gen_in[5] = 1'b0;
      cyc(1, 0, 1, "R7 high channel resync low");

      @(posedge clk); #1;
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired before the scenario ended");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule